// File: doc/BRIEF.md
# PDM Microphone Output Power Controller

This block stands in for the digital output side of a pulse-density-modulated microphone. It runs on a free-running reference clock and watches the PDM clock that a host supplies. When that clock stops toggling for long enough, the block drops into sleep and releases the shared data line. Once the clock comes back, it stays asleep for a fixed number of PDM clock periods, and only then starts driving.

While awake, the block puts the bit from an external modulator onto a shared tri-state data line. It drives only during one half of each PDM clock period, so a second device on the other half can share the wire. The select input picks the half. The bit is captured when the drive window opens and is held unchanged until the window closes. A synchronous reset returns the block to sleep.

Top module: `pdm_mic_pwr_ctrl`

## Requirements
- R1: When no PDM clock edge has been seen for more than IDLE_LIMIT reference cycles, `awake` falls within IDLE_LIMIT+6 reference cycles of the last edge. It stays high for at least IDLE_LIMIT+2 cycles after that edge.
- R2: While `awake` is low, `dout_oe` is low, including the whole wake-up period after the clock resumes.
- R3: After the PDM clock becomes active, `awake` rises only on the WAKE_CYCLES-th PDM rising edge, counted from the first edge after inactivity or reset. It is low after the (WAKE_CYCLES-1)-th edge.
- R4: With `sel_left` = 0 (right half), the line is driven from each PDM falling edge until the following rising edge, and `dout_oe` is low in the other half.
- R5: With `sel_left` = 1 (left half), the line is driven from each PDM rising edge until the following falling edge, and `dout_oe` is low in the other half.
- R6: `dout` equals the value `mod_bit` had at the launch edge and stays constant while `dout_oe` is high, even if `mod_bit` changes.
- R7: A synchronous reset (`rst` = 1) forces `awake` = 0 and `dout_oe` = 0 on the next clock.
- R8: A PDM clock that stops before the wake count completes discards the partial count, so a full WAKE_CYCLES rising edges are needed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous reset, active high |
| pdm_clk | input | 1 | PDM clock from the host, asynchronous to clk |
| sel_left | input | 1 | 0: drive in the low half (right), 1: drive in the high half (left) |
| mod_bit | input | 1 | Modulator output bit to transmit |
| dout | output | 1 | Value for the shared data line |
| dout_oe | output | 1 | Output enable for the tri-state driver |
| awake | output | 1 | High when the block is out of sleep |

## Verification
The hardest cases to reach are a clock that stops in the middle of a wake count, and a clock that stops during a driven half-cycle. In the first case the count must start again from zero. In the second case the enable must fall once sleep is declared, not at a release edge. The bench drives the PDM clock one half-period at a time from tasks. This lets it stop the clock after a chosen number of rising edges or at a chosen level, wait a measured number of reference cycles on each side of the inactivity limit, and then count the full wake sequence again. Random modulator bits and occasional select changes run between these directed stops.

// File: rtl/pdm_mic_pwr_ctrl.sv
module pdm_mic_pwr_ctrl #(
  parameter int IDLE_LIMIT  = 100000,
  parameter int WAKE_CYCLES = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic pdm_clk,
  input  logic sel_left,
  input  logic mod_bit,
  output logic dout,
  output logic dout_oe,
  output logic awake
);
  localparam int IW = $clog2(IDLE_LIMIT + 2);
  localparam int WW = $clog2(WAKE_CYCLES + 1);
  localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_LIMIT + 1);
  localparam logic [WW-1:0] WAKE_MAX = WW'(WAKE_CYCLES);

  logic [2:0]    sync_q;
  logic [IW-1:0] idle_cnt;
  logic [WW-1:0] wake_cnt;

  always_ff @(posedge clk)
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], pdm_clk};

  wire rise     = sync_q[1] & ~sync_q[2];
  wire fall     = ~sync_q[1] & sync_q[2];
  wire inactive = (idle_cnt == IDLE_MAX);
  wire launch   = sel_left ? rise : fall;
  wire release_e = sel_left ? fall : rise;

  always_ff @(posedge clk)
    if (rst)                   idle_cnt <= IDLE_MAX;
    else if (rise | fall)      idle_cnt <= '0;
    else if (!inactive)        idle_cnt <= idle_cnt + 1'b1;

  always_ff @(posedge clk)
    if (rst)                   wake_cnt <= '0;
    else if (rise) begin
      if (inactive)            wake_cnt <= WW'(1);
      else if (wake_cnt != WAKE_MAX) wake_cnt <= wake_cnt + 1'b1;
    end
    else if (inactive)         wake_cnt <= '0;

  assign awake = (wake_cnt == WAKE_MAX);

  always_ff @(posedge clk)
    if (rst || !awake) begin
      dout_oe <= 1'b0;
      dout    <= 1'b0;
    end else if (launch && !dout_oe) begin
      dout_oe <= 1'b1;
      dout    <= mod_bit;
    end else if (release_e) begin
      dout_oe <= 1'b0;
    end

  assert_idle_sleeps_R1: assert property (@(posedge clk) disable iff (rst)
    inactive && !rise |=> !awake);
  assert_sleep_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !awake |=> !dout_oe);
  assert_wake_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(awake) |-> $past(rise));
  assert_wake_cap_R3: assert property (@(posedge clk) disable iff (rst)
    wake_cnt <= WAKE_MAX);
  assert_hold_bit_R6: assert property (@(posedge clk) disable iff (rst)
    dout_oe && $past(dout_oe) |-> $stable(dout));
  assert_reset_state_R7: assert property (@(posedge clk)
    rst |=> !awake && !dout_oe);
endmodule

// File: tb/pdm_mic_pwr_ctrl_tb.sv
module pdm_mic_pwr_ctrl_tb_top;
  localparam int IDLE = 20;
  localparam int WAKE = 64;

  logic clk = 1'b0, rst = 1'b1, pdm_clk = 1'b0, sel_left = 1'b0, mod_bit = 1'b0;
  logic dout, dout_oe, awake;

  int n_chk = 0, n_bad = 0, rises = 0, settle = 0;
  bit prev_drive = 0, prev_bit = 0, done = 0;

  pdm_mic_pwr_ctrl #(.IDLE_LIMIT(IDLE), .WAKE_CYCLES(WAKE)) dut_i (
    .clk(clk), .rst(rst), .pdm_clk(pdm_clk), .sel_left(sel_left),
    .mod_bit(mod_bit), .dout(dout), .dout_oe(dout_oe), .awake(awake));

  always #5 clk = ~clk;

  function automatic bit exp_oe(bit sel, bit level);
    return sel ? level : !level;
  endfunction

  function automatic bit exp_awake(int n);
    return n >= WAKE;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic half();
    bit chk_en;
    pdm_clk = ~pdm_clk;
    mod_bit = 1'($urandom);
    if (pdm_clk) rises++;
    #10;
    if (prev_drive) begin
      check("R6 oe held into release", dout_oe, 1);
      check("R6 latched bit", dout, prev_bit);
    end
    #20;
    chk_en = (rises >= WAKE + 1) && (settle == 0);
    if (chk_en) begin
      prev_drive = exp_oe(sel_left, pdm_clk);
      prev_bit   = mod_bit;
      check(sel_left ? "R5 left enable" : "R4 right enable", dout_oe, prev_drive);
      if (prev_drive) check(sel_left ? "R5 left data" : "R4 right data", dout, mod_bit);
    end else begin
      prev_drive = 0;
      if (rises < WAKE) check("R2 quiet while waking", dout_oe, 0);
    end
    if (settle > 0) settle--;
    #10;
  endtask

  task automatic run_to(int n);
    while (rises < n) half();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(posedge clk);
    #1;
    check("R7 reset awake", awake, 0);
    check("R7 reset oe", dout_oe, 0);
    @(posedge clk); rst = 1'b0; #5;

    #300;
    check("R2 asleep without clock awake", awake, 0);
    check("R2 asleep without clock oe", dout_oe, 0);

    run_to(WAKE - 1);
    check("R3 not awake one edge early", awake, exp_awake(rises));
    run_to(WAKE);
    check("R3 awake on final edge", awake, exp_awake(rises));

    for (int i = 0; i < 400; i++) begin
      if (pdm_clk && ($urandom % 16 == 0)) begin
        sel_left = ~sel_left;
        settle = 3;
        prev_drive = 0;
      end
      half();
    end

    #160;
    check("R1 still awake before limit", awake, 1);
    #80;
    check("R1 asleep after idle", awake, 0);
    check("R2 oe released on sleep", dout_oe, 0);
    rises = 0; prev_drive = 0;

    sel_left = 1'b1;
    run_to(40);
    #300;
    check("R8 partial count asleep", awake, 0);
    rises = 0;
    run_to(WAKE - 1);
    check("R8 partial count discarded", awake, exp_awake(rises));
    run_to(WAKE);
    check("R8 full recount wakes", awake, exp_awake(rises));
    for (int i = 0; i < 200; i++) half();

    if (pdm_clk) half();
    rst = 1'b1;
    #20;
    check("R7 reset mid-run awake", awake, 0);
    check("R7 reset mid-run oe", dout_oe, 0);
    rst = 1'b0; rises = 0; prev_drive = 0;
    #100;
    check("R7 asleep after reset", awake, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule